// File: doc/BRIEF.md
# Snapshot Record Read Shifter

This block is the device side of a four-wire serial read path for a metering core. A long pulse on the sync pin while chip select is idle copies every measurement record into a bank of transmission latches. The serial master then takes chip select low. It shifts the snapshot out one bit per serial clock, 32 clocks per record, in a fixed order of seven groups of four records.

Each 32-bit record holds a 28-bit data field under a 4-bit parity nibble. The parity nibble is seeded by the record's group number. The record leaves the pin least significant byte first. Within each byte the bits go most significant first, unless a configuration input reverses them.

A master can skip the early groups. With sync low it clocks one or more precharge bytes of all ones into the data pin, and each such byte moves the starting group forward by one. Reading the snapshot again without a new latch pulse returns the same data. The measurement sources lie outside the block and arrive on a flat input bus.

Top module: `rdsh_top`

## Requirements
- R1: After reset, and whenever chip select is high, `sda_o` is 1 and `sda_oe` is 0.
- R2: Holding `sync` high with `cs_n` high for at least LATCH_MIN (default 3) consecutive clock cycles copies all records from `rec_data` into the latches. A shorter pulse leaves the latches unchanged.
- R3: `sda_oe` is 1 exactly while `cs_n` is 0 and `sync` is 1 (read mode). With `sync` low (write mode), `sda_o` stays 1.
- R4: Read mode begins at bit 0 of the first record of the current start group in two cases: when `sync` rises while `cs_n` is low, and when `cs_n` falls while `sync` is high.
- R5: Each latched record is the word {parity[3:0], data[27:0]}. Its byte 0 (bits 7:0) is sent first and byte 3 (bits 31:24) last.
- R6: With `lsb_first`=0, each byte goes out bit 7 first. With `lsb_first`=1, each byte goes out bit 0 first.
- R7: For record r in group g=r/4, the parity nibble P satisfies P ^ g ^ (XOR of the seven data nibbles) = 4'hF.
- R8: Each rising `sclk` edge in read mode advances one bit. After 32 edges the next record, in increasing index order, begins.
- R9: In write mode, a byte of eight `sda_in` bits (first bit most significant) taken on rising `sclk` edges advances the start group by one only if it equals 8'hFF. Any other byte leaves the group unchanged. The group saturates at 6 and returns to 0 while `cs_n` is high.
- R10: After the last record (index 27) has been shifted, `sda_o` holds 1 until chip select rises.
- R11: A second read session with no latch pulse in between returns the same words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sync | input | 1 | Latch strobe when `cs_n` is high; read (1) or write (0) select when `cs_n` is low |
| sclk | input | 1 | Serial clock, idle high; the bit advances on its rising edge |
| sda_in | input | 1 | Serial data from the master in write mode |
| lsb_first | input | 1 | Bit order inside each byte: 0 sends the most significant bit first |
| rec_data | input | 784 | 28 data fields of 28 bits; record r occupies bits [28r+27:28r] |
| sda_o | output | 1 | Serial data to the master |
| sda_oe | output | 1 | Output enable for `sda_o` |

## Verification
The assertions take it for granted that all pins are synchronous to `clk` and hold for at least one clock between changes. They also assume that `sclk` only toggles while `cs_n` is low. The edge-based properties on `sync`, the group pointer and the cursor depend on these conditions. The stimulus changes pins only on falling clock edges. It keeps each `sclk` phase two clocks wide, never raises `sync` and `sclk` in the same cycle, and drops `cs_n` together with `sync` whenever it starts a session with sync already high, so that no unintended latch pulse occurs.

// File: rtl/rdsh_pkg.sv
package rdsh_pkg;

    localparam int WORD_W    = 32;
    localparam int PAR_W     = 4;
    localparam int BYTE_W    = 8;
    localparam int DATA_W    = WORD_W - PAR_W;
    localparam int NIB_N     = DATA_W / PAR_W;
    localparam int BIT_IDX_W = $clog2(WORD_W);

    localparam logic [BYTE_W-1:0] PRECHARGE_CODE = 8'hFF;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_READ  = 2'd2
    } pin_mode_e;

    typedef struct packed {
        logic sclk_rise;
        logic sync_rise;
        logic cs_fall;
        logic latch_fire;
    } pin_evt_t;

    // Parity nibble: XOR of group seed, seven data nibbles and result is all ones.
    function automatic logic [PAR_W-1:0] parity_nibble(
        input logic [PAR_W-1:0]  grp,
        input logic [DATA_W-1:0] d
    );
        logic [PAR_W-1:0] acc;
        acc = grp;
        for (int n = 0; n < NIB_N; n++) begin
            acc = acc ^ d[n*PAR_W +: PAR_W];
        end
        return ~acc;
    endfunction

    // Serial bit index -> bit position inside the 32-bit word.
    function automatic logic [BIT_IDX_W-1:0] wire_to_word_pos(
        input logic [BIT_IDX_W-1:0] idx,
        input logic                 lsb_first
    );
        logic [2:0] k;
        logic [1:0] byte_sel;
        k        = idx[2:0];
        byte_sel = idx[4:3];
        return {byte_sel, (lsb_first ? k : (3'd7 - k))};
    endfunction

endpackage

// File: rtl/rdsh_pin_decode.sv
module rdsh_pin_decode
    import rdsh_pkg::*;
#(
    parameter int LATCH_MIN = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      sync,
    input  logic      sclk,
    output pin_mode_e mode,
    output pin_evt_t  evt
);
    localparam int HOLD_W = $clog2(LATCH_MIN + 1);

    logic              sclk_d;
    logic              sync_d;
    logic              cs_d;
    logic [HOLD_W-1:0] hold_cnt;
    logic              latch_arm;

    assign latch_arm = cs_n & sync;

    always_comb begin
        if (cs_n)      mode = MODE_IDLE;
        else if (sync) mode = MODE_READ;
        else           mode = MODE_WRITE;
    end

    always_comb begin
        evt.sclk_rise  = sclk & ~sclk_d;
        evt.sync_rise  = sync & ~sync_d;
        evt.cs_fall    = ~cs_n & cs_d;
        evt.latch_fire = latch_arm && (hold_cnt == HOLD_W'(LATCH_MIN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b1;
            sync_d   <= 1'b0;
            cs_d     <= 1'b1;
            hold_cnt <= '0;
        end else begin
            sclk_d <= sclk;
            sync_d <= sync;
            cs_d   <= cs_n;
            if (!latch_arm) begin
                hold_cnt <= '0;
            end else if (hold_cnt != HOLD_W'(LATCH_MIN)) begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rdsh_latch_bank.sv
module rdsh_latch_bank
    import rdsh_pkg::*;
#(
    parameter int N_GROUPS       = 7,
    parameter int RECS_PER_GROUP = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             capture,
    input  logic [N_GROUPS*RECS_PER_GROUP*DATA_W-1:0] rec_data,
    output logic [N_GROUPS*RECS_PER_GROUP*WORD_W-1:0] words_flat
);
    localparam int NREC = N_GROUPS * RECS_PER_GROUP;

    logic [PAR_W-1:0] par [NREC];

    for (genvar r = 0; r < NREC; r++) begin : g_par
        assign par[r] = parity_nibble(PAR_W'(r / RECS_PER_GROUP),
                                      rec_data[r*DATA_W +: DATA_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words_flat <= '0;
        end else if (capture) begin
            for (int r = 0; r < NREC; r++) begin
                words_flat[r*WORD_W +: WORD_W] <= {par[r], rec_data[r*DATA_W +: DATA_W]};
            end
        end
    end

endmodule

// File: rtl/rdsh_cursor.sv
module rdsh_cursor
    import rdsh_pkg::*;
#(
    parameter int N_GROUPS       = 7,
    parameter int RECS_PER_GROUP = 4,
    localparam int NREC  = N_GROUPS * RECS_PER_GROUP,
    localparam int REC_W = $clog2(NREC + 1),
    localparam int GRP_W = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pin_mode_e            mode,
    input  pin_evt_t             evt,
    input  logic                 sda_in,
    output logic [REC_W-1:0]     rec_idx,
    output logic [BIT_IDX_W-1:0] bit_idx,
    output logic [GRP_W-1:0]     grp_ptr
);
    logic [BYTE_W-1:0] wr_shift;
    logic [2:0]        wr_cnt;
    logic [BYTE_W-1:0] wr_next;

    assign wr_next = {wr_shift[BYTE_W-2:0], sda_in};

    // Start group and precharge byte assembly
    always_ff @(posedge clk) begin
        if (rst) begin
            grp_ptr  <= '0;
            wr_shift <= '0;
            wr_cnt   <= '0;
        end else if (mode == MODE_IDLE) begin
            grp_ptr <= '0;
            wr_cnt  <= '0;
        end else if (mode == MODE_WRITE) begin
            if (evt.sclk_rise) begin
                wr_shift <= wr_next;
                wr_cnt   <= wr_cnt + 1'b1;
                if (wr_cnt == 3'd7 && wr_next == PRECHARGE_CODE &&
                    grp_ptr < GRP_W'(N_GROUPS - 1)) begin
                    grp_ptr <= grp_ptr + 1'b1;
                end
            end
        end else if (evt.sync_rise) begin
            wr_cnt <= '0;
        end
    end

    // Read cursor
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_idx <= REC_W'(NREC);
            bit_idx <= '0;
        end else if (mode == MODE_READ) begin
            if (evt.sync_rise || evt.cs_fall) begin
                rec_idx <= REC_W'(int'(grp_ptr) * RECS_PER_GROUP);
                bit_idx <= '0;
            end else if (evt.sclk_rise && rec_idx < REC_W'(NREC)) begin
                bit_idx <= bit_idx + 1'b1;
                if (bit_idx == BIT_IDX_W'(WORD_W - 1)) begin
                    rec_idx <= rec_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rdsh_bit_out.sv
module rdsh_bit_out
    import rdsh_pkg::*;
#(
    parameter int N_GROUPS       = 7,
    parameter int RECS_PER_GROUP = 4,
    localparam int NREC  = N_GROUPS * RECS_PER_GROUP,
    localparam int REC_W = $clog2(NREC + 1)
) (
    input  logic [NREC*WORD_W-1:0] words_flat,
    input  logic [REC_W-1:0]       rec_idx,
    input  logic [BIT_IDX_W-1:0]   bit_idx,
    input  logic                   lsb_first,
    input  pin_mode_e              mode,
    output logic                   sda_o,
    output logic                   sda_oe
);
    logic [WORD_W-1:0]    cur_word;
    logic [BIT_IDX_W-1:0] pos;

    assign pos = wire_to_word_pos(bit_idx, lsb_first);

    always_comb begin
        cur_word = '1;
        if (rec_idx < REC_W'(NREC)) begin
            cur_word = words_flat[int'(rec_idx)*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        sda_oe = (mode == MODE_READ);
        sda_o  = sda_oe ? cur_word[pos] : 1'b1;
    end

endmodule

// File: rtl/rdsh_top.sv
module rdsh_top
    import rdsh_pkg::*;
#(
    parameter int N_GROUPS       = 7,
    parameter int RECS_PER_GROUP = 4,
    parameter int LATCH_MIN      = 3
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      cs_n,
    input  logic                                      sync,
    input  logic                                      sclk,
    input  logic                                      sda_in,
    input  logic                                      lsb_first,
    input  logic [N_GROUPS*RECS_PER_GROUP*28-1:0]     rec_data,
    output logic                                      sda_o,
    output logic                                      sda_oe
);
    localparam int NREC  = N_GROUPS * RECS_PER_GROUP;
    localparam int REC_W = $clog2(NREC + 1);
    localparam int GRP_W = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;

    pin_mode_e            mode;
    pin_evt_t             evt;
    logic                 latch_fire;
    logic [NREC*WORD_W-1:0] words_flat;
    logic [REC_W-1:0]     rec_idx;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [GRP_W-1:0]     grp_ptr;

    assign latch_fire = evt.latch_fire;

    rdsh_pin_decode #(.LATCH_MIN(LATCH_MIN)) u_dec (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sync (sync),
        .sclk (sclk),
        .mode (mode),
        .evt  (evt)
    );

    rdsh_latch_bank #(.N_GROUPS(N_GROUPS), .RECS_PER_GROUP(RECS_PER_GROUP)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .capture    (latch_fire),
        .rec_data   (rec_data),
        .words_flat (words_flat)
    );

    rdsh_cursor #(.N_GROUPS(N_GROUPS), .RECS_PER_GROUP(RECS_PER_GROUP)) u_cur (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .evt     (evt),
        .sda_in  (sda_in),
        .rec_idx (rec_idx),
        .bit_idx (bit_idx),
        .grp_ptr (grp_ptr)
    );

    rdsh_bit_out #(.N_GROUPS(N_GROUPS), .RECS_PER_GROUP(RECS_PER_GROUP)) u_out (
        .words_flat (words_flat),
        .rec_idx    (rec_idx),
        .bit_idx    (bit_idx),
        .lsb_first  (lsb_first),
        .mode       (mode),
        .sda_o      (sda_o),
        .sda_oe     (sda_oe)
    );

endmodule

// File: rtl/rdsh_chk.sv
module rdsh_chk #(
    parameter int N_GROUPS       = 7,
    parameter int RECS_PER_GROUP = 4,
    localparam int NREC  = N_GROUPS * RECS_PER_GROUP,
    localparam int REC_W = $clog2(NREC + 1),
    localparam int GRP_W = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               cs_n,
    input logic               sync,
    input logic               sda_o,
    input logic               sda_oe,
    input logic [GRP_W-1:0]   grp_ptr,
    input logic [REC_W-1:0]   rec_idx,
    input logic [4:0]         bit_idx,
    input logic               capture,
    input logic [NREC*32-1:0] words_flat
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sda_oe && sda_o));

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(words_flat));

    // R4
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $rose(sync)) |=> (bit_idx == 5'd0));

    // R9
    grp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_ptr != $past(grp_ptr)) |-> (grp_ptr == $past(grp_ptr) + 1'b1 || grp_ptr == '0));

    // R9
    grp_range_chk: assert property (@(posedge clk) disable iff (rst)
        grp_ptr < GRP_W'(N_GROUPS));

    // R10
    tail_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && sync && rec_idx == REC_W'(NREC)) |-> sda_o);

endmodule

bind rdsh_top rdsh_chk #(.N_GROUPS(N_GROUPS), .RECS_PER_GROUP(RECS_PER_GROUP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sync       (sync),
    .sda_o      (sda_o),
    .sda_oe     (sda_oe),
    .grp_ptr    (grp_ptr),
    .rec_idx    (rec_idx),
    .bit_idx    (bit_idx),
    .capture    (latch_fire),
    .words_flat (words_flat)
);

// File: tb/sim_rdsh_top.sv
module sim_rdsh_top;
    localparam int NG   = 7;
    localparam int RPG  = 4;
    localparam int NREC = NG * RPG;
    localparam int LMIN = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sync = 1'b0;
    logic sclk = 1'b1;
    logic sda_in = 1'b1;
    logic lsb_first = 1'b0;
    logic [NREC*28-1:0] rec_data = '0;
    logic sda_o;
    logic sda_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rdsh_top #(.N_GROUPS(NG), .RECS_PER_GROUP(RPG), .LATCH_MIN(LMIN)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sync(sync), .sclk(sclk),
        .sda_in(sda_in), .lsb_first(lsb_first), .rec_data(rec_data),
        .sda_o(sda_o), .sda_oe(sda_oe)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [31:0] m_words [NREC];
    int m_grp = 0, m_rec = NREC, m_bit = 0, m_wcnt = 0, m_wsh = 0, m_hold = 0;
    logic p_sclk = 1'b1, p_sync = 1'b0, p_cs = 1'b1;

    function automatic logic [31:0] mk_word(input int r);
        logic [27:0] d;
        logic [3:0]  acc;
        d   = rec_data[r*28 +: 28];
        acc = 4'(r / RPG);
        for (int n = 0; n < 7; n++) acc = acc ^ d[n*4 +: 4];
        return {~acc, d};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_grp = 0; m_rec = NREC; m_bit = 0; m_wcnt = 0; m_wsh = 0; m_hold = 0;
            for (int r = 0; r < NREC; r++) m_words[r] = '0;
            p_sclk = 1'b1; p_sync = 1'b0; p_cs = 1'b1;
        end else begin
            if (cs_n && sync) begin
                m_hold++;
                if (m_hold == LMIN) for (int r = 0; r < NREC; r++) m_words[r] = mk_word(r);
            end else begin
                m_hold = 0;
            end
            if (cs_n) begin
                m_grp = 0; m_wcnt = 0;
            end else if (!sync) begin
                if (sclk && !p_sclk) begin
                    m_wsh = ((m_wsh << 1) | int'(sda_in)) & 255;
                    m_wcnt++;
                    if (m_wcnt == 8) begin
                        m_wcnt = 0;
                        if (m_wsh == 255 && m_grp < NG - 1) m_grp++;
                    end
                end
            end else begin
                if ((sync && !p_sync) || (!cs_n && p_cs)) begin
                    m_rec = m_grp * RPG; m_bit = 0; m_wcnt = 0;
                end else if (sclk && !p_sclk && m_rec < NREC) begin
                    m_bit++;
                    if (m_bit == 32) begin m_bit = 0; m_rec++; end
                end
            end
            p_sclk = sclk; p_sync = sync; p_cs = cs_n;
        end
        #2;
        begin
            logic e_oe, e_sda;
            int pos;
            e_oe  = !cs_n && sync;
            e_sda = 1'b1;
            if (e_oe && m_rec < NREC) begin
                pos   = (m_bit / 8) * 8 + (lsb_first ? (m_bit % 8) : 7 - (m_bit % 8));
                e_sda = m_words[m_rec][pos];
            end
            if (!rst) check(sda_oe == e_oe && sda_o == e_sda, "R3,R8 per-cycle model",
                            {30'd0, sda_oe, sda_o}, {30'd0, e_oe, e_sda});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_data(input int seed);
        for (int r = 0; r < NREC; r++) begin
            logic [27:0] v;
            v = 28'(r * 32'h0135799 + seed * 32'h0A5A5A5);
            if (r == 0) v = (seed == 0) ? 28'h0000001 : 28'h0000003;
            if (r == 4) v = 28'h0000000;
            if (r == 8) v = 28'h2222222;
            rec_data[r*28 +: 28] = v;
        end
    endtask

    task automatic latch_pulse(input int len);
        @(negedge clk); cs_n = 1'b1; sync = 1'b1;
        repeat (len) @(negedge clk);
        sync = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic sclk_bit(output logic b);
        @(negedge clk); sclk = 1'b0;
        repeat (2) @(negedge clk);
        b = sda_o; sclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic open_read();
        @(negedge clk); cs_n = 1'b0; sync = 1'b0;
        @(negedge clk); sync = 1'b1;
        @(negedge clk);
    endtask

    task automatic close_sess();
        @(negedge clk); sync = 1'b0; cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_word(output logic [31:0] w);
        logic b;
        w = '0;
        for (int i = 0; i < 32; i++) begin
            sclk_bit(b);
            w[(i / 8) * 8 + (lsb_first ? (i % 8) : 7 - (i % 8))] = b;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            sda_in = v[i];
            sclk_bit(b);
        end
        sda_in = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
        finish_run();
    end

    initial begin
        logic [31:0] w;
        logic [7:0]  seq;
        logic        b;
        set_data(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(sda_o == 1'b1 && sda_oe == 1'b0, "R1 reset state", {30'd0, sda_oe, sda_o}, 32'd1);

        latch_pulse(LMIN);

        // R5 R7 R8: full sweep, then R10 tail
        open_read();
        for (int r = 0; r < NREC; r++) begin
            read_word(w);
            check(w == m_words[r], "R8 record sequence", w, m_words[r]);
            if (r == 0) check(w == 32'hE0000001, "R5 record0 word", w, 32'hE0000001);
            if (r == 4) check(w == 32'hE0000000, "R7 group1 seed", w, 32'hE0000000);
            if (r == 8) check(w == 32'hF2222222, "R7 group2 parity", w, 32'hF2222222);
        end
        for (int i = 0; i < 4; i++) begin
            sclk_bit(b);
            check(b == 1'b1, "R10 tail idle level", {31'd0, b}, 32'd1);
        end
        close_sess();

        // R11: repeat without latch
        open_read();
        read_word(w);
        check(w == 32'hE0000001, "R11 repeat read", w, 32'hE0000001);
        close_sess();

        // R2: short pulse ignored, full pulse captures
        set_data(1);
        latch_pulse(LMIN - 1);
        open_read();
        read_word(w);
        check(w == 32'hE0000001, "R2 short pulse ignored", w, 32'hE0000001);
        close_sess();
        latch_pulse(LMIN);
        open_read();
        read_word(w);
        check(w == 32'hC0000003, "R2 capture", w, 32'hC0000003);
        close_sess();

        // R6: bit order inside a byte
        open_read();
        seq = '0;
        for (int i = 0; i < 8; i++) begin sclk_bit(b); seq = {seq[6:0], b}; end
        check(seq == 8'h03, "R6 msb first", {24'd0, seq}, 32'h03);
        close_sess();
        lsb_first = 1'b1;
        open_read();
        seq = '0;
        for (int i = 0; i < 8; i++) begin sclk_bit(b); seq = {seq[6:0], b}; end
        check(seq == 8'hC0, "R6 lsb first", {24'd0, seq}, 32'hC0);
        close_sess();
        open_read();
        for (int r = 0; r < 4; r++) begin
            read_word(w);
            check(w == m_words[r], "R6 lsb first words", w, m_words[r]);
        end
        close_sess();
        lsb_first = 1'b0;

        // R9: two precharges -> group 2; write mode quiet (R3)
        @(negedge clk); cs_n = 1'b0; sync = 1'b0;
        @(negedge clk);
        check(sda_oe == 1'b0 && sda_o == 1'b1, "R3 write mode quiet", {30'd0, sda_oe, sda_o}, 32'd1);
        send_byte(8'hFF);
        send_byte(8'hFF);
        @(negedge clk); sync = 1'b1;
        @(negedge clk);
        check(sda_oe == 1'b1, "R3 read mode enable", {31'd0, sda_oe}, 32'd1);
        read_word(w);
        check(w == 32'hF2222222, "R9 two precharges", w, 32'hF2222222);
        close_sess();

        // R9: non-FF byte ignored
        @(negedge clk); cs_n = 1'b0; sync = 1'b0;
        send_byte(8'hFE);
        send_byte(8'hFF);
        @(negedge clk); sync = 1'b1;
        @(negedge clk);
        read_word(w);
        check(w == 32'hE0000000, "R9 non-FF ignored", w, 32'hE0000000);
        close_sess();

        // R9 saturation then R10
        @(negedge clk); cs_n = 1'b0; sync = 1'b0;
        for (int i = 0; i < 8; i++) send_byte(8'hFF);
        @(negedge clk); sync = 1'b1;
        @(negedge clk);
        for (int r = 24; r < NREC; r++) begin
            read_word(w);
            check(w == m_words[r], "R9 saturated start", w, m_words[r]);
        end
        sclk_bit(b);
        check(b == 1'b1, "R10 after saturated read", {31'd0, b}, 32'd1);
        close_sess();

        // R4: cs falls with sync high; restart mid-word
        @(negedge clk); cs_n = 1'b0; sync = 1'b1;
        @(negedge clk);
        read_word(w);
        check(w == 32'hC0000003, "R4 cs fall start", w, 32'hC0000003);
        for (int i = 0; i < 9; i++) sclk_bit(b);
        @(negedge clk); sync = 1'b0;
        @(negedge clk); sync = 1'b1;
        @(negedge clk);
        read_word(w);
        check(w == 32'hC0000003, "R4 sync restart", w, 32'hC0000003);
        close_sess();

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule